// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Condition Flags

This block is the single-cycle byte shifter of a small 16-bit processor datapath. It picks one byte-wide half of the eight 16-bit general registers as its operand, applies one of eight one-position shift or rotate operations, and returns the shifted byte together with a refreshed condition byte. It is purely combinational: the controller presents the register bank, a half-register select, an opcode and the current condition byte, and captures both outputs at the end of the same cycle.

Four operations move bits in a ring (plain, or through the carry flag), and four shift with either a zero fill or a sign fill. The bit that leaves the byte always becomes the new carry. Negative, zero and overflow flags are derived from the result; the upper nibble of the condition byte is carried through untouched so that control bits held there survive a shift instruction.

Top module: `byte_shift_unit`

## Requirements
- R1: `sel_i` value k selects byte k of `bank_i` (bits 8k+7 down to 8k) as the operand, where even k is the high half and odd k the low half of register k/2 (0 = R0 high, 1 = R0 low, ... 15 = R7 low).
- R2: Opcode 3'b000 rotates the operand left by one (bit 7 into bit 0); opcode 3'b001 rotates it right by one (bit 0 into bit 7).
- R3: Opcode 3'b010 rotates left through carry (incoming C, `ccr_i[0]`, enters bit 0); opcode 3'b011 rotates right through carry (incoming C enters bit 7).
- R4: Opcode 3'b100 is an arithmetic left shift filling bit 0 with zero; opcode 3'b101 is an arithmetic right shift that keeps bit 7.
- R5: Opcode 3'b110 is a logical left shift filling bit 0 with zero; opcode 3'b111 is a logical right shift filling bit 7 with zero.
- R6: The new C (`ccr_o[0]`) is the operand bit shifted or rotated out: operand bit 7 for left operations (opcode bit 0 clear), operand bit 0 for right operations.
- R7: The new N (`ccr_o[3]`) equals result bit 7, and the new Z (`ccr_o[2]`) is set exactly when the result is zero.
- R8: The new V (`ccr_o[1]`) is operand bit 7 XOR operand bit 6 for opcode 3'b100 and zero for every other opcode.
- R9: `ccr_o[7:4]` equals `ccr_i[7:4]` for every opcode and operand.
- R10: The incoming carry has no effect on `result_o` for any opcode other than 3'b010 and 3'b011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bank_i | input | 128 | Sixteen register halves, byte k at bits 8k+7:8k |
| sel_i | input | 4 | Operand byte select |
| op_i | input | 3 | Shift or rotate opcode |
| ccr_i | input | 8 | Current condition byte (N=3, Z=2, V=1, C=0) |
| result_o | output | 8 | Shifted or rotated byte |
| ccr_o | output | 8 | Updated condition byte |

## Verification
Since the unit holds no state, a fault in the select decode, the fill bit choice or the flag logic shows up at `result_o` or `ccr_o` in the very cycle the offending inputs are applied, with no delay to wait out. A swapped opcode decode shows as a byte that is off by one bit position or has the wrong fill, and a misrouted carry shows in `ccr_o[0]` and, for the through-carry rotates, in the vacated result bit. Random operands over all selects and opcodes, plus directed all-zero, all-one and sign-change patterns, reach each such fault quickly.

// File: rtl/byte_shift_pkg.sv
package byte_shift_pkg;

  typedef enum logic [2:0] {
    OP_ROL  = 3'b000,
    OP_ROR  = 3'b001,
    OP_ROLC = 3'b010,
    OP_RORC = 3'b011,
    OP_ASL  = 3'b100,
    OP_ASR  = 3'b101,
    OP_LSL  = 3'b110,
    OP_LSR  = 3'b111
  } shift_op_e;

  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_V = 1;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_N = 3;

endpackage

// File: rtl/bsu_operand_mux.sv
module bsu_operand_mux #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned NUM_B  = 1 << SEL_W,
  localparam int unsigned BANK_W = NUM_B * BYTE_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [BYTE_W-1:0] operand_o
);

  logic [BYTE_W-1:0] lane [NUM_B];

  for (genvar k = 0; k < NUM_B; k++) begin : g_lane
    assign lane[k] = bank_i[k*BYTE_W +: BYTE_W];
  end

  assign operand_o = lane[sel_i];

endmodule

// File: rtl/bsu_shift_core.sv
module bsu_shift_core
  import byte_shift_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] opnd_i,
  input  shift_op_e         op_i,
  input  logic              carry_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              out_bit_o,
  output logic              ovf_o
);

  localparam int unsigned MSB = BYTE_W - 1;

  logic left;
  logic fill;

  // left ops share an even opcode
  assign left      = ~op_i[0];
  assign out_bit_o = left ? opnd_i[MSB] : opnd_i[0];

  always_comb begin
    unique case (op_i)
      OP_ROL:  fill = opnd_i[MSB];
      OP_ROR:  fill = opnd_i[0];
      OP_ROLC: fill = carry_i;
      OP_RORC: fill = carry_i;
      OP_ASR:  fill = opnd_i[MSB];
      default: fill = 1'b0;
    endcase
  end

  assign res_o = left ? {opnd_i[MSB-1:0], fill} : {fill, opnd_i[MSB:1]};
  assign ovf_o = (op_i == OP_ASL) ? (opnd_i[MSB] ^ opnd_i[MSB-1]) : 1'b0;

endmodule

// File: rtl/bsu_flag_gen.sv
module bsu_flag_gen
  import byte_shift_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] res_i,
  input  logic              out_bit_i,
  input  logic              ovf_i,
  input  logic [7:0]        ccr_i,
  output logic [7:0]        ccr_o
);

  always_comb begin
    ccr_o         = ccr_i;
    ccr_o[FLAG_N] = res_i[BYTE_W-1];
    ccr_o[FLAG_Z] = (res_i == '0);
    ccr_o[FLAG_V] = ovf_i;
    ccr_o[FLAG_C] = out_bit_i;
  end

endmodule

// File: rtl/byte_shift_unit.sv
module byte_shift_unit
  import byte_shift_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned BANK_W = (1 << SEL_W) * BYTE_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [2:0]        op_i,
  input  logic [7:0]        ccr_i,
  output logic [BYTE_W-1:0] result_o,
  output logic [7:0]        ccr_o
);

  logic [BYTE_W-1:0] opnd;
  logic              out_bit;
  logic              ovf;
  shift_op_e         op;

  assign op = shift_op_e'(op_i);

  bsu_operand_mux #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_mux (
    .bank_i    (bank_i),
    .sel_i     (sel_i),
    .operand_o (opnd)
  );

  bsu_shift_core #(.BYTE_W(BYTE_W)) u_core (
    .opnd_i    (opnd),
    .op_i      (op),
    .carry_i   (ccr_i[FLAG_C]),
    .res_o     (result_o),
    .out_bit_o (out_bit),
    .ovf_o     (ovf)
  );

  bsu_flag_gen #(.BYTE_W(BYTE_W)) u_flags (
    .res_i     (result_o),
    .out_bit_i (out_bit),
    .ovf_i     (ovf),
    .ccr_i     (ccr_i),
    .ccr_o     (ccr_o)
  );

endmodule

// File: rtl/byte_shift_unit_chk.sv
module byte_shift_unit_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned BANK_W = (1 << SEL_W) * BYTE_W
) (
  input logic [BANK_W-1:0] bank_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [2:0]        op_i,
  input logic [7:0]        ccr_i,
  input logic [BYTE_W-1:0] result_o,
  input logic [7:0]        ccr_o
);

  logic [BYTE_W-1:0] src;
  assign src = bank_i[sel_i*BYTE_W +: BYTE_W];

  always_comb begin
    // R6
    carry_out_chk: assert (ccr_o[0] == (op_i[0] ? src[0] : src[BYTE_W-1]));
    // R7
    neg_flag_chk: assert (ccr_o[3] == result_o[BYTE_W-1]);
    // R7
    zero_flag_chk: assert (ccr_o[2] == (result_o == '0));
    // R8
    ovf_flag_chk: assert (op_i == 3'b100 ? (ccr_o[1] == (src[BYTE_W-1] ^ result_o[BYTE_W-1]))
                                         : (ccr_o[1] == 1'b0));
    // R9
    upper_keep_chk: assert (ccr_o[7:4] == ccr_i[7:4]);
    // R2
    rot_weight_chk: assert (op_i[2:1] != 2'b00 || $countones(result_o) == $countones(src));
    // R3
    rotc_fill_chk: assert (op_i != 3'b010 || result_o[0] == ccr_i[0]);
  end

endmodule

bind byte_shift_unit byte_shift_unit_chk #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_chk (
  .bank_i   (bank_i),
  .sel_i    (sel_i),
  .op_i     (op_i),
  .ccr_i    (ccr_i),
  .result_o (result_o),
  .ccr_o    (ccr_o)
);

// File: tb/byte_shift_unit_test.sv
`timescale 1ns/1ps
module byte_shift_unit_test;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] bank_i = '0;
  logic [3:0]   sel_i = '0;
  logic [2:0]   op_i = '0;
  logic [7:0]   ccr_i = '0;
  logic [7:0]   result_o;
  logic [7:0]   ccr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_shift_unit uut (
    .bank_i   (bank_i),
    .sel_i    (sel_i),
    .op_i     (op_i),
    .ccr_i    (ccr_i),
    .result_o (result_o),
    .ccr_o    (ccr_o)
  );

  function automatic logic [15:0] model(input logic [7:0] a, input logic [2:0] op,
                                        input logic [7:0] cc);
    logic [7:0] r;
    logic       c, v;
    v = 1'b0;
    case (op)
      3'b000: begin r = {a[6:0], a[7]}; c = a[7]; end
      3'b001: begin r = {a[0], a[7:1]}; c = a[0]; end
      3'b010: begin r = {a[6:0], cc[0]}; c = a[7]; end
      3'b011: begin r = {cc[0], a[7:1]}; c = a[0]; end
      3'b100: begin r = {a[6:0], 1'b0}; c = a[7]; v = a[7] ^ a[6]; end
      3'b101: begin r = {a[7], a[7:1]}; c = a[0]; end
      3'b110: begin r = {a[6:0], 1'b0}; c = a[7]; end
      default: begin r = {1'b0, a[7:1]}; c = a[0]; end
    endcase
    return {r, cc[7:4], r[7], (r == 8'h00), v, c};
  endfunction

  function automatic string op_req(input logic [2:0] op);
    case (op[2:1])
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual res=%h ccr=%h expected res=%h ccr=%h",
               req, act[15:8], act[7:0], exp[15:8], exp[7:0]);
    end
  endtask

  // apply away from the rising edge, sample at the falling edge
  task automatic apply(input logic [3:0] s, input logic [2:0] op, input logic [7:0] cc,
                       input string req);
    @(posedge clk); #2;
    sel_i = s; op_i = op; ccr_i = cc;
    @(negedge clk);
    check(req, {result_o, ccr_o}, model(bank_i[s*8 +: 8], op, cc));
  endtask

  task automatic apply_byte(input logic [7:0] a, input logic [2:0] op, input logic [7:0] cc,
                            input string req);
    @(posedge clk); #2;
    bank_i[5*8 +: 8] = a;
    apply(4'd5, op, cc, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // reset-like idle state: all-zero inputs
    @(negedge clk);
    check("R7", {result_o, ccr_o}, 16'h0004);

    // R1: each select reaches its own byte
    for (int k = 0; k < 16; k++) bank_i[k*8 +: 8] = 8'(8'h11 * k) ^ 8'h5A;
    for (int k = 0; k < 16; k++) apply(4'(k), 3'b110, 8'h00, "R1");

    // directed corners per opcode
    for (int op = 0; op < 8; op++) begin
      apply_byte(8'h80, 3'(op), 8'hA0, op_req(3'(op)));
      apply_byte(8'h01, 3'(op), 8'h51, op_req(3'(op)));
      apply_byte(8'hFF, 3'(op), 8'hF0, op_req(3'(op)));
      apply_byte(8'h00, 3'(op), 8'h3F, op_req(3'(op)));
    end

    // R6 carry-out at both ends
    apply_byte(8'h81, 3'b000, 8'h00, "R6");
    apply_byte(8'h7E, 3'b111, 8'h01, "R6");
    // R7 zero from a non-zero operand
    apply_byte(8'h80, 3'b110, 8'h00, "R7");
    apply_byte(8'h01, 3'b111, 8'h00, "R7");
    // R8 sign change vs none
    apply_byte(8'h40, 3'b100, 8'h00, "R8");
    apply_byte(8'hC0, 3'b100, 8'h00, "R8");
    apply_byte(8'h40, 3'b110, 8'h00, "R8");
    // R9 upper nibble kept
    apply_byte(8'h33, 3'b101, 8'hC6, "R9");

    // R10: carry in ignored outside through-carry rotates
    for (int op = 0; op < 8; op++) begin
      logic [7:0] r0;
      if (op == 2 || op == 3) continue;
      apply_byte(8'h96, 3'(op), 8'h00, "R10");
      r0 = result_o;
      apply_byte(8'h96, 3'(op), 8'h01, "R10");
      checks++;
      if (result_o !== r0) begin
        failures++;
        $display("FAIL R10: actual res=%h expected res=%h", result_o, r0);
      end
    end

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      @(posedge clk); #2;
      for (int k = 0; k < 4; k++) bank_i[k*32 +: 32] = $urandom;
      op = 3'($urandom);
      apply(4'($urandom), op, 8'($urandom), op_req(op));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule